// File: doc/BRIEF.md
# YUV 4:4:4 to 4:2:2 Chroma Formatter

This block takes one YUV pixel per clock, with all three 8-bit components present, and produces either a 4:4:4 stream or a 4:2:2 stream. In the packed 4:2:2 form, luma stays on its own bus. The two chroma components take turns on a second bus, and the third bus is held at the neutral chroma code. Configuration bits choose the packed or the pass-through form, which chroma component leads, and whether chroma is averaged with the previous pixel or simply decimated.

A `line_start` pulse marks the start of every video line. It captures the configuration for that line and restarts the chroma alternation, so the first valid pixel of a line always carries the leading component. A per-pixel `blank` input forces the neutral YUV code. Every mode has the same one-cycle latency, so a downstream timing chain never has to depend on the configuration.

Top module: `yuv422_formatter`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid pixel, out_valid is 0, out_y is 0x00, and out_c and out_x are 0x80.
- R2: out_valid equals in_valid delayed by exactly one clock. The pixel data for an input cycle appears on the output buses in that same delayed cycle, in every mode.
- R3: With the captured format bit at 0 (4:4:4), out_y, out_c and out_x carry in_y, in_u and in_v of the same pixel, unchanged.
- R4: With the captured format bit at 1 (4:2:2), out_y carries in_y, out_x is held at 0x80, and out_c carries chroma as set by R5 to R7.
- R5: In 4:2:2, pixels in a line are counted from 0. With cfg_v_first at 0, even positions carry U and odd positions carry V. With cfg_v_first at 1 the assignment is swapped.
- R6: In 4:2:2 with cfg_drop_odd at 1, an even position carries its own pixel's leading component. An odd position carries the trailing component of the preceding even pixel, so the odd pixel's chroma is discarded.
- R7: In 4:2:2 with cfg_drop_odd at 0, the chroma output is (a+b+1)>>1. Here a is the selected component of the current pixel and b is the same component of the previous valid pixel in the line. For the first pixel of a line, b equals a.
- R8: The position count restarts at 0 on the first valid pixel in or after a cycle with line_start high. Cycles with in_valid low do not advance it.
- R9: cfg_pack422, cfg_v_first and cfg_drop_odd take effect only in a cycle with line_start high, starting with a pixel in that same cycle. Changes at other times have no effect on the line in progress.
- R10: A valid pixel with blank high produces out_y = 0x00 and out_c = out_x = 0x80 in both formats, with the same latency as R2.
- R11: In a cycle with in_valid low, the output data buses keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Line-start pulse; captures mode bits and restarts chroma phase |
| in_valid | input | 1 | Input pixel qualifier |
| in_y | input | 8 | Input luma |
| in_u | input | 8 | Input U chroma |
| in_v | input | 8 | Input V chroma |
| cfg_pack422 | input | 1 | 0: 4:4:4 pass-through, 1: packed 4:2:2 |
| cfg_v_first | input | 1 | 0: U leads on chroma bus, 1: V leads |
| cfg_drop_odd | input | 1 | 0: averaged chroma, 1: odd chroma dropped |
| blank | input | 1 | Force neutral YUV output for this pixel |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Chroma (4:2:2 alternating, or U in 4:4:4) |
| out_x | output | 8 | V in 4:4:4, 0x80 in 4:2:2 |

## Verification
Capturing new mode bits and restarting the chroma phase can fall in the same cycle, because one `line_start` does both. The first pixel of that line must then already use the new mode, the new leading component and an unaveraged chroma value. The stimulus table provokes this by raising `line_start` together with a valid pixel and changed mode bits. The output one cycle later is judged against the hand-computed value for the new mode. A second case raises `line_start` in a cycle with no valid pixel, to show that the restart waits for the next valid pixel.

// File: rtl/yuv422_formatter.sv
module yuv422_formatter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_u,
  input  logic [DW-1:0] in_v,
  input  logic          cfg_pack422,
  input  logic          cfg_v_first,
  input  logic          cfg_drop_odd,
  input  logic          blank,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic [DW-1:0] out_x
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic          fmt_q, ord_q, drp_q;
  logic          first_q, phase_q;
  logic [DW-1:0] prev_u, prev_v;

  wire fmt_e   = line_start ? cfg_pack422  : fmt_q;
  wire ord_e   = line_start ? cfg_v_first  : ord_q;
  wire drp_e   = line_start ? cfg_drop_odd : drp_q;
  wire first_e = first_q | line_start;
  wire ph      = first_e ? 1'b0 : phase_q;

  wire [DW-1:0] pu = first_e ? in_u : prev_u;
  wire [DW-1:0] pv = first_e ? in_v : prev_v;

  wire          take_v   = ph ^ ord_e;
  wire [DW-1:0] sel_cur  = take_v ? in_v : in_u;
  wire [DW-1:0] sel_prev = take_v ? pv : pu;
  wire [DW:0]   sum      = {1'b0, sel_cur} + {1'b0, sel_prev} + (DW+1)'(1);
  wire [DW-1:0] c_filt   = sum[DW:1];
  wire [DW-1:0] c_drop   = ph ? sel_prev : sel_cur;
  wire [DW-1:0] c422     = drp_e ? c_drop : c_filt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q     <= 1'b0;
      ord_q     <= 1'b0;
      drp_q     <= 1'b0;
      first_q   <= 1'b1;
      phase_q   <= 1'b0;
      prev_u    <= '0;
      prev_v    <= '0;
      out_valid <= 1'b0;
      out_y     <= '0;
      out_c     <= MID;
      out_x     <= MID;
    end else begin
      out_valid <= in_valid;
      if (line_start) begin
        fmt_q <= cfg_pack422;
        ord_q <= cfg_v_first;
        drp_q <= cfg_drop_odd;
      end
      if (in_valid) begin
        first_q <= 1'b0;
        phase_q <= ~ph;
        prev_u  <= in_u;
        prev_v  <= in_v;
        out_y   <= blank ? '0 : in_y;
        out_c   <= blank ? MID : (fmt_e ? c422 : in_u);
        out_x   <= (blank || fmt_e) ? MID : in_v;
      end else if (line_start) begin
        first_q <= 1'b1;
      end
    end
  end

  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_y) && $stable(out_c) && $stable(out_x)));
  p_spare_mid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fmt_e) |=> (out_x == MID));
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !fmt_e && !blank) |=>
      (out_y == $past(in_y) && out_c == $past(in_u) && out_x == $past(in_v)));
  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && blank) |=> (out_y == '0 && out_c == MID && out_x == MID));
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(fmt_q) && $stable(ord_q) && $stable(drp_q)));
  p_phase_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !in_valid) |=> first_q);
endmodule

// File: tb/sim_yuv422_formatter.sv
module sim_yuv422_formatter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, in_valid = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0;
  logic cfg_pack422 = 1'b0, cfg_v_first = 1'b0, cfg_drop_odd = 1'b0, blank = 1'b0;
  logic out_valid;
  logic [7:0] out_y, out_c, out_x;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  yuv422_formatter u0 (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_valid(in_valid),
    .in_y(in_y), .in_u(in_u), .in_v(in_v),
    .cfg_pack422(cfg_pack422), .cfg_v_first(cfg_v_first), .cfg_drop_odd(cfg_drop_odd),
    .blank(blank), .out_valid(out_valid), .out_y(out_y), .out_c(out_c), .out_x(out_x)
  );

  // {ls,val,fmt,ord,drp,blk, y,u,v, exp_valid, exp_y,exp_c,exp_x}
  localparam int N = 17;
  localparam logic [54:0] VEC [N] = '{
    {6'b110000, 8'h10, 8'h20, 8'h30, 1'b1, 8'h10, 8'h20, 8'h30},
    {6'b010000, 8'h11, 8'h21, 8'h31, 1'b1, 8'h11, 8'h21, 8'h31},
    {6'b111010, 8'h40, 8'h50, 8'h60, 1'b1, 8'h40, 8'h50, 8'h80},
    {6'b010000, 8'h41, 8'h52, 8'h62, 1'b1, 8'h41, 8'h60, 8'h80},
    {6'b000000, 8'h99, 8'h99, 8'h99, 1'b0, 8'h41, 8'h60, 8'h80},
    {6'b010000, 8'h42, 8'h54, 8'h64, 1'b1, 8'h42, 8'h54, 8'h80},
    {6'b010000, 8'h43, 8'h56, 8'h66, 1'b1, 8'h43, 8'h64, 8'h80},
    {6'b111100, 8'h50, 8'hA0, 8'hB0, 1'b1, 8'h50, 8'hB0, 8'h80},
    {6'b010010, 8'h51, 8'hA3, 8'hB3, 1'b1, 8'h51, 8'hA2, 8'h80},
    {6'b010000, 8'h52, 8'h10, 8'h21, 1'b1, 8'h52, 8'h6A, 8'h80},
    {6'b010001, 8'h53, 8'h30, 8'h50, 1'b1, 8'h00, 8'h80, 8'h80},
    {6'b010000, 8'h54, 8'h20, 8'h40, 1'b1, 8'h54, 8'h48, 8'h80},
    {6'b101000, 8'h00, 8'h00, 8'h00, 1'b0, 8'h54, 8'h48, 8'h80},
    {6'b010000, 8'h60, 8'hFF, 8'h00, 1'b1, 8'h60, 8'hFF, 8'h80},
    {6'b010000, 8'h61, 8'h01, 8'hFF, 1'b1, 8'h61, 8'h80, 8'h80},
    {6'b110001, 8'h77, 8'h12, 8'h34, 1'b1, 8'h00, 8'h80, 8'h80},
    {6'b010000, 8'h70, 8'h71, 8'h72, 1'b1, 8'h70, 8'h71, 8'h72}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1, 16: return "R3";
      2:        return "R4";
      3, 6:     return "R6";
      4, 12:    return "R11";
      5, 13:    return "R8";
      7:        return "R5";
      8, 9, 11, 14: return "R7";
      10, 15:   return "R10";
      default:  return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [24:0] exp);
    logic [24:0] act;
    act = {out_valid, out_y, out_c, out_x};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got v=%b y=%h c=%h x=%h, expected v=%b y=%h c=%h x=%h",
               req, act[24], act[23:16], act[15:8], act[7:0],
               exp[24], exp[23:16], exp[15:8], exp[7:0]);
    end
  endtask

  task automatic apply(logic [54:0] e);
    {line_start, in_valid, cfg_pack422, cfg_v_first, cfg_drop_odd, blank} = e[54:49];
    in_y = e[48:41];
    in_u = e[40:33];
    in_v = e[32:25];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {1'b0, 8'h00, 8'h80, 8'h80});  // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {1'b0, 8'h00, 8'h80, 8'h80});  // R1 after release, idle
    // Table: R2 latency throughout; entries 2 and 7 combine capture (R9) with restart (R8)
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (i > 0) check(tag_of(i - 1), VEC[i - 1][24:0]);
      apply(VEC[i]);
    end
    @(negedge clk);
    check(tag_of(N - 1), VEC[N - 1][24:0]);
    apply('0);
    @(negedge clk);
    check("R2", {1'b0, 8'h70, 8'h71, 8'h72});  // R2: valid drops one cycle later
    // Directed: 4:2:2 V-first drop mode, line started with no valid pixel
    line_start = 1'b1; cfg_pack422 = 1'b1; cfg_v_first = 1'b1; cfg_drop_odd = 1'b1;
    @(negedge clk);
    line_start = 1'b0; cfg_pack422 = 1'b0; cfg_v_first = 1'b0; cfg_drop_odd = 1'b0;
    in_valid = 1'b1; in_y = 8'h01; in_u = 8'h02; in_v = 8'h03;
    @(negedge clk);
    check("R6", {1'b1, 8'h01, 8'h03, 8'h80});
    in_y = 8'h04; in_u = 8'h05; in_v = 8'h06;
    @(negedge clk);
    check("R6", {1'b1, 8'h04, 8'h02, 8'h80});  // odd position: held U of even pixel
    // Reset mid-stream returns to reset state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {1'b0, 8'h00, 8'h80, 8'h80});
    rst_n = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R1", {1'b0, 8'h00, 8'h80, 8'h80});
    finish_run();
  end
endmodule